// File: doc/BRIEF.md
# Multicycle Control Sequencer with Load-and-Bump-Base

This block is the control state machine of a multicycle datapath that shares one memory and one ALU across several cycles per instruction. It issues one control word per cycle from its current state alone (Moore style). Every instruction starts with a common fetch cycle and a common decode cycle. After decode the sequencer follows the path of the instruction class that the opcode field of the instruction register selects.

Four classes are recognised: word load, word store, register-register ALU operation, and a load that also advances its base register. The last class reads memory at base plus sign-extended offset. It writes the loaded word to the destination register, then adds four to the base register and writes the sum back. That takes six cycles with two register writes, and the datapath's register-destination mux needs a third input, the base field, bits 25-21.

The datapath, the register file and the memory are outside this block.

Top module: `mc_ldinc_ctrl`

## Requirements
- R1: While rst_ni is low every output is 0. The first rising edge after release enters the fetch state.
- R2: Fetch drives mem_rd=1, i_or_d=0, ir_wr=1, pc_wr=1, pc_src=00, alu_src_a=0, alu_src_b=01 (constant 4) and alu_op=00 (add). All other outputs are 0. Fetch is always followed by decode.
- R3: Decode drives alu_src_a=0, alu_src_b=11 (shifted offset) and alu_op=00. All other outputs are 0, including mem_rd, pc_wr and ir_wr.
- R4: The address cycle follows decode for opcode 0x23 (load), 0x2B (store) and 0x3A (load-and-bump). It drives alu_src_a=1, alu_src_b=10 (sign-extended offset) and alu_op=00.
- R5: For load and load-and-bump, the address cycle is followed by a memory-read cycle with mem_rd=1 and i_or_d=1.
- R6: A load writes back with reg_wr=1, mem_to_reg=1 and reg_dst=00 (bits 20-16), then returns to fetch. The whole load takes 5 cycles.
- R7: A store follows the address cycle with one cycle of mem_wr=1 and i_or_d=1, then returns to fetch. The whole store takes 4 cycles.
- R8: Opcode 0x00 runs an execute cycle with alu_src_a=1, alu_src_b=00 (register) and alu_op=10 (function field). That is followed by a writeback with reg_wr=1, reg_dst=01 (bits 15-11) and mem_to_reg=0, then fetch.
- R9: Cycle 5 of load-and-bump drives reg_wr=1, mem_to_reg=1, reg_dst=00, alu_src_a=1, alu_src_b=01 and alu_op=00.
- R10: Cycle 6 of load-and-bump drives reg_wr=1, mem_to_reg=0 and reg_dst=10 (bits 25-21), then returns to fetch.
- R11: Any other opcode returns from decode to fetch with no register or memory write.
- R12: mem_wr is never high together with mem_rd or with reg_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| i_or_d_o | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| ir_wr_o | output | 1 | Instruction register load |
| pc_wr_o | output | 1 | PC load |
| pc_src_o | output | 2 | PC source select, 00 = ALU result |
| alu_src_a_o | output | 1 | ALU A select: 0 = PC, 1 = register A |
| alu_src_b_o | output | 2 | ALU B select: 00 register B, 01 constant 4, 10 offset, 11 offset shifted by 2 |
| alu_op_o | output | 2 | ALU operation: 00 add, 10 from function field |
| reg_wr_o | output | 1 | Register file write enable |
| mem_to_reg_o | output | 1 | Write data select: 0 = ALU result register, 1 = memory data |
| reg_dst_o | output | 2 | Write register select: 00 bits 20-16, 01 bits 15-11, 10 bits 25-21 |

## Verification
Each control word belongs to the state entered at the preceding rising edge, so it is due in that same cycle. No extra register sits between the state and the ports.

The driver sets the opcode just after the edge that enters fetch. It then queues one expected word per cycle for the whole instruction, so a load queues five words and load-and-bump queues six. The monitor compares one word at each falling edge, halfway through the cycle that word belongs to.

Reset acts asynchronously, so the bench checks its all-zero outputs a moment after it asserts reset, including in the middle of an instruction.

// File: rtl/mc_ldinc_pkg.sv
package mc_ldinc_pkg;

  typedef enum logic [3:0] {
    ST_BOOT, ST_FETCH, ST_DECODE, ST_ADDR, ST_RDMEM, ST_LDWB,
    ST_STMEM, ST_REXEC, ST_RWB, ST_LIWB, ST_LIBASE
  } state_e;

  typedef enum logic [2:0] {
    CL_LOAD, CL_STORE, CL_RTYPE, CL_LDINC, CL_OTHER
  } iclass_e;

  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;
  localparam logic [1:0] SRCB_BR   = 2'b11;
  localparam logic [1:0] DST_RT    = 2'b00;
  localparam logic [1:0] DST_RD    = 2'b01;
  localparam logic [1:0] DST_BASE  = 2'b10;
  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_FUNCT = 2'b10;
  localparam logic [1:0] PCS_ALU   = 2'b00;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       i_or_d;
    logic       ir_wr;
    logic       pc_wr;
    logic [1:0] pc_src;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic       reg_wr;
    logic       mem_to_reg;
    logic [1:0] reg_dst;
  } ctrl_t;

endpackage

// File: rtl/mc_ldinc_opdec.sv
module mc_ldinc_opdec
  import mc_ldinc_pkg::*;
#(
  parameter int unsigned     OP_W      = 6,
  parameter logic [OP_W-1:0] OPC_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OPC_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OPC_STORE = 6'h2b,
  parameter logic [OP_W-1:0] OPC_LDINC = 6'h3a
) (
  input  logic [OP_W-1:0] opcode_i,
  output iclass_e         class_o
);

  always_comb begin
    if (opcode_i == OPC_RTYPE)      class_o = CL_RTYPE;
    else if (opcode_i == OPC_LOAD)  class_o = CL_LOAD;
    else if (opcode_i == OPC_STORE) class_o = CL_STORE;
    else if (opcode_i == OPC_LDINC) class_o = CL_LDINC;
    else                            class_o = CL_OTHER;
  end

endmodule

// File: rtl/mc_ldinc_next.sv
module mc_ldinc_next
  import mc_ldinc_pkg::*;
(
  input  state_e  state_i,
  input  iclass_e class_i,
  output state_e  state_o
);

  always_comb begin
    state_o = ST_FETCH;
    unique case (state_i)
      ST_BOOT:   state_o = ST_FETCH;
      ST_FETCH:  state_o = ST_DECODE;
      ST_DECODE: begin
        unique case (class_i)
          CL_LOAD, CL_STORE, CL_LDINC: state_o = ST_ADDR;
          CL_RTYPE:                    state_o = ST_REXEC;
          default:                     state_o = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        unique case (class_i)
          CL_STORE:         state_o = ST_STMEM;
          CL_LOAD, CL_LDINC: state_o = ST_RDMEM;
          default:          state_o = ST_FETCH;
        endcase
      end
      // shared read cycle, exit picks the writeback flavour
      ST_RDMEM:  state_o = (class_i == CL_LDINC) ? ST_LIWB : ST_LDWB;
      ST_REXEC:  state_o = ST_RWB;
      ST_LIWB:   state_o = ST_LIBASE;
      ST_LDWB, ST_STMEM, ST_RWB, ST_LIBASE: state_o = ST_FETCH;
      default:   state_o = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ldinc_outdec.sv
module mc_ldinc_outdec
  import mc_ldinc_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.ir_wr     = 1'b1;
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.pc_src    = PCS_ALU;
        ctrl_o.alu_src_b = SRCB_FOUR;
        ctrl_o.alu_op    = ALU_ADD;
      end
      ST_DECODE: begin
        ctrl_o.alu_src_b = SRCB_BR;
        ctrl_o.alu_op    = ALU_ADD;
      end
      ST_ADDR: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_src_b = SRCB_IMM;
        ctrl_o.alu_op    = ALU_ADD;
      end
      ST_RDMEM: begin
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.i_or_d = 1'b1;
      end
      ST_LDWB: begin
        ctrl_o.reg_wr     = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_dst    = DST_RT;
      end
      ST_STMEM: begin
        ctrl_o.mem_wr = 1'b1;
        ctrl_o.i_or_d = 1'b1;
      end
      ST_REXEC: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_src_b = SRCB_REG;
        ctrl_o.alu_op    = ALU_FUNCT;
      end
      ST_RWB: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.reg_dst = DST_RD;
      end
      // data writeback overlapped with base + 4 in the ALU
      ST_LIWB: begin
        ctrl_o.reg_wr     = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_dst    = DST_RT;
        ctrl_o.alu_src_a  = 1'b1;
        ctrl_o.alu_src_b  = SRCB_FOUR;
        ctrl_o.alu_op     = ALU_ADD;
      end
      ST_LIBASE: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.reg_dst = DST_BASE;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mc_ldinc_ctrl.sv
module mc_ldinc_ctrl
  import mc_ldinc_pkg::*;
#(
  parameter int unsigned     OP_W      = 6,
  parameter logic [OP_W-1:0] OPC_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OPC_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OPC_STORE = 6'h2b,
  parameter logic [OP_W-1:0] OPC_LDINC = 6'h3a
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            i_or_d_o,
  output logic            ir_wr_o,
  output logic            pc_wr_o,
  output logic [1:0]      pc_src_o,
  output logic            alu_src_a_o,
  output logic [1:0]      alu_src_b_o,
  output logic [1:0]      alu_op_o,
  output logic            reg_wr_o,
  output logic            mem_to_reg_o,
  output logic [1:0]      reg_dst_o
);

  state_e  state_q, state_d;
  iclass_e iclass;
  ctrl_t   ctrl;

  mc_ldinc_opdec #(
    .OP_W(OP_W), .OPC_RTYPE(OPC_RTYPE), .OPC_LOAD(OPC_LOAD),
    .OPC_STORE(OPC_STORE), .OPC_LDINC(OPC_LDINC)
  ) u_opdec (
    .opcode_i(opcode_i),
    .class_o (iclass)
  );

  mc_ldinc_next u_next (
    .state_i(state_q),
    .class_i(iclass),
    .state_o(state_d)
  );

  // boot state keeps every enable low until the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_BOOT;
    else         state_q <= state_d;
  end

  mc_ldinc_outdec u_outdec (
    .state_i(state_q),
    .ctrl_o (ctrl)
  );

  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign i_or_d_o     = ctrl.i_or_d;
  assign ir_wr_o      = ctrl.ir_wr;
  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_src_o     = ctrl.pc_src;
  assign alu_src_a_o  = ctrl.alu_src_a;
  assign alu_src_b_o  = ctrl.alu_src_b;
  assign alu_op_o     = ctrl.alu_op;
  assign reg_wr_o     = ctrl.reg_wr;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign reg_dst_o    = ctrl.reg_dst;

endmodule

// File: rtl/mc_ldinc_ctrl_chk.sv
module mc_ldinc_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       i_or_d_o,
  input logic       ir_wr_o,
  input logic       pc_wr_o,
  input logic       alu_src_a_o,
  input logic [1:0] alu_src_b_o,
  input logic [1:0] alu_op_o,
  input logic       reg_wr_o,
  input logic       mem_to_reg_o,
  input logic [1:0] reg_dst_o
);

  // R3
  fetch_then_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |=> (!ir_wr_o && !pc_wr_o && !mem_rd_o && alu_src_b_o == 2'b11));

  // R4
  addr_then_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_src_b_o == 2'b10) |=> i_or_d_o);

  // R5
  read_then_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && i_or_d_o) |=> (reg_wr_o && mem_to_reg_o && reg_dst_o == 2'b00));

  // R6
  load_wb_then_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && mem_to_reg_o && !alu_src_a_o) |=> (ir_wr_o && pc_wr_o));

  // R7
  store_then_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> ir_wr_o);

  // R8
  rexec_then_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_o == 2'b10) |=> (reg_wr_o && !mem_to_reg_o && reg_dst_o == 2'b01));

  // R9
  bump_then_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && mem_to_reg_o && alu_src_a_o) |=>
      (reg_wr_o && !mem_to_reg_o && reg_dst_o == 2'b10));

  // R10
  base_then_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_dst_o == 2'b10) |=> (ir_wr_o && pc_wr_o));

  // R12
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_wr_o && (mem_rd_o || reg_wr_o)));

endmodule

bind mc_ldinc_ctrl mc_ldinc_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .i_or_d_o    (i_or_d_o),
  .ir_wr_o     (ir_wr_o),
  .pc_wr_o     (pc_wr_o),
  .alu_src_a_o (alu_src_a_o),
  .alu_src_b_o (alu_src_b_o),
  .alu_op_o    (alu_op_o),
  .reg_wr_o    (reg_wr_o),
  .mem_to_reg_o(mem_to_reg_o),
  .reg_dst_o   (reg_dst_o)
);

// File: tb/mc_ldinc_ctrl_tb.sv
`timescale 1ns/1ps
module mc_ldinc_ctrl_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = 6'h00;
  logic       mem_rd_o, mem_wr_o, i_or_d_o, ir_wr_o, pc_wr_o;
  logic [1:0] pc_src_o, alu_src_b_o, alu_op_o, reg_dst_o;
  logic       alu_src_a_o, reg_wr_o, mem_to_reg_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk_i = ~clk_i;

  mc_ldinc_ctrl u_dut (.*);

  // field order: mem_rd mem_wr i_or_d ir_wr pc_wr pc_src src_a src_b alu_op reg_wr m2r reg_dst
  wire [15:0] act = {mem_rd_o, mem_wr_o, i_or_d_o, ir_wr_o, pc_wr_o, pc_src_o,
                     alu_src_a_o, alu_src_b_o, alu_op_o, reg_wr_o, mem_to_reg_o, reg_dst_o};

  localparam logic [15:0] W_FETCH  = {5'b10011, 2'b00, 1'b0, 2'b01, 2'b00, 2'b00, 2'b00};
  localparam logic [15:0] W_DECODE = {5'b00000, 2'b00, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00};
  localparam logic [15:0] W_ADDR   = {5'b00000, 2'b00, 1'b1, 2'b10, 2'b00, 2'b00, 2'b00};
  localparam logic [15:0] W_RDMEM  = {5'b10100, 2'b00, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00};
  localparam logic [15:0] W_LDWB   = {5'b00000, 2'b00, 1'b0, 2'b00, 2'b00, 2'b11, 2'b00};
  localparam logic [15:0] W_STMEM  = {5'b01100, 2'b00, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00};
  localparam logic [15:0] W_REXEC  = {5'b00000, 2'b00, 1'b1, 2'b00, 2'b10, 2'b00, 2'b00};
  localparam logic [15:0] W_RWB    = {5'b00000, 2'b00, 1'b0, 2'b00, 2'b00, 2'b10, 2'b01};
  localparam logic [15:0] W_LIWB   = {5'b00000, 2'b00, 1'b1, 2'b01, 2'b00, 2'b11, 2'b00};
  localparam logic [15:0] W_LIBASE = {5'b00000, 2'b00, 1'b0, 2'b00, 2'b00, 2'b10, 2'b10};

  task automatic check(input logic [15:0] a, input logic [15:0] e, input string tag);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, a, e, $time);
    end
  endtask

  task automatic push(input logic [15:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // driver: starts an instruction at the edge that enters fetch
  task automatic run_instr(input logic [5:0] op);
    wait (exp_q.size() == 0);
    @(posedge clk_i); #1;
    opcode_i = op;
    push(W_FETCH, "R2 fetch");
    push(W_DECODE, "R3 decode");
    case (op)
      6'h23: begin
        push(W_ADDR, "R4 addr"); push(W_RDMEM, "R5 read"); push(W_LDWB, "R6 load wb");
      end
      6'h2b: begin
        push(W_ADDR, "R4 addr"); push(W_STMEM, "R7 store");
      end
      6'h00: begin
        push(W_REXEC, "R8 exec"); push(W_RWB, "R8 wb");
      end
      6'h3a: begin
        push(W_ADDR, "R4 addr"); push(W_RDMEM, "R5 read");
        push(W_LIWB, "R9 data wb"); push(W_LIBASE, "R10 base wb");
      end
      default: ;
    endcase
    // next instruction's fetch verifies return to fetch (R6 R7 R8 R10 R11)
  endtask

  // monitor: compares mid-cycle
  always @(negedge clk_i) begin
    if (rst_ni && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(act, e, t);
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(act, 16'h0000, "R1 in reset");
    rst_ni = 1'b1;
    check(act, 16'h0000, "R1 after release before edge");
    run_instr(6'h23);
    run_instr(6'h2b);
    run_instr(6'h00);
    run_instr(6'h3a);
    run_instr(6'h04);   // R11 unrecognised
    run_instr(6'h3a);
    run_instr(6'h3f);   // R11 unrecognised
    run_instr(6'h23);
    run_instr(6'h00);
    run_instr(6'h2b);
    run_instr(6'h3a);
    // R1: reset in the middle of load-and-bump
    wait (exp_q.size() == 0);
    @(posedge clk_i); #1;
    opcode_i = 6'h3a;
    @(posedge clk_i); #1;
    @(posedge clk_i); #1;
    rst_ni = 1'b0;
    #1;
    check(act, 16'h0000, "R1 async mid-instruction");
    @(negedge clk_i);
    check(act, 16'h0000, "R1 held in reset");
    rst_ni = 1'b1;
    run_instr(6'h3a);
    run_instr(6'h23);
    wait (exp_q.size() == 0);
    @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule